// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block tracks a processor package as it moves down through its idle power states and back up again. There are five levels: Normal, Stop-Grant, Sleep, Deep Sleep and Deeper Sleep. The levels are strictly nested, and the block moves only one level per transition. Four active-low control inputs, each resynchronised inside the block, drive the moves: stop-clock, sleep, deep-sleep and deeper-stop.

The block reports the following:
- the current level;
- a voltage-identification code, which drops to a reduced value while in Deeper Sleep;
- enables for snoop response and interrupt latching;
- a flag for the PLL settle wait;
- a sticky flag that catches forbidden input activity while the package is in a deep state.

Both cores supply their requested idle level and performance level. From these the block raises a request to leave Deeper Sleep.

The block runs on a reference clock that never stops, so the PLL settle time after Deep Sleep can be counted even while the bus clock is halted. The count is set by a parameter. At 50 MHz, 15 µs is 750 cycles.

Top module: `pwr_state_seq`

## Requirements
- R1: While the active-low reset `rstN` is low, from any level including Sleep, the block is held in Normal with the following outputs. It never passes through Stop-Grant.
  - `pwrState` = 0.
  - `vidCode` = VID_NORM.
  - Both enables are 1.
  - `pllWait` = 0.
  - `violation` = 0.
- R2: Asserting stop-clock (low) in Normal moves to Stop-Grant (`pwrState` = 1). Releasing it in Stop-Grant returns to Normal (0).
- R3: Asserting sleep in Stop-Grant moves to Sleep (`pwrState` = 2). Releasing sleep in Sleep returns to Stop-Grant. Sleep asserted in Normal has no effect.
- R4: Deep Sleep (`pwrState` = 3) is entered only from Sleep when deep-sleep is asserted. Deep-sleep asserted in Stop-Grant has no effect.
- R5: Deeper Sleep (`pwrState` = 4) is entered only from Deep Sleep when deeper-stop is asserted. Deeper-stop asserted in Sleep has no effect.
- R6: `vidCode` equals VID_LOW exactly while in Deeper Sleep. Releasing deeper-stop returns to Deep Sleep and restores VID_NORM in the same cycle.
- R7: Releasing deep-sleep in Deep Sleep enters the PLL wait (`pwrState` = 5, `pllWait` = 1). The block stays there for exactly SETTLE_CYC cycles, then enters Sleep.
- R8: `snoopEn` and `intEn` are 0 in Deep Sleep, Deeper Sleep and the PLL wait, and 1 in every other level.
- R9: `exitReq` is 1 only in Deeper Sleep, and only when at least one of the following holds:
  - either core's idle request differs from 4 (C4);
  - either core's performance request differs from the all-ones lowest point.
- R10: `violation` is set and held until reset when a synchronised control input changes while in one of these levels, other than the inputs listed as allowed:
  - Deep Sleep: deep-sleep and deeper-stop are allowed;
  - Deeper Sleep: only deeper-stop is allowed;
  - the PLL wait: no input is allowed.
- R11: Each control input passes through two synchronising flops. A change at the pins alters `pwrState` on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stpClkN | input | 1 | Stop-clock request, active low |
| slpN | input | 1 | Sleep request, active low |
| dpSlpN | input | 1 | Deep-sleep request, active low |
| dprStpN | input | 1 | Deeper-stop request, active low |
| core0Idle | input | CST_W | Core 0 requested idle level |
| core1Idle | input | CST_W | Core 1 requested idle level |
| core0Perf | input | PST_W | Core 0 requested performance level |
| core1Perf | input | PST_W | Core 1 requested performance level |
| pwrState | output | 3 | Current level code |
| vidCode | output | VID_W | Voltage identification code |
| snoopEn | output | 1 | Snoop response enable |
| intEn | output | 1 | Interrupt latching enable |
| pllWait | output | 1 | PLL settle wait in progress |
| exitReq | output | 1 | Request to leave Deeper Sleep |
| violation | output | 1 | Sticky protocol-violation flag |

## Verification
The bench builds the block with SETTLE_CYC = 5, PST_W = 2 and CST_W = 3. A short settle makes it practical to time the whole PLL wait cycle by cycle. The narrow request fields allow every combination of the two cores' idle and performance codes, all 1024, to be swept while in Deeper Sleep. The distinct VID_NORM and VID_LOW codes make the voltage switch visible on the exact cycle of entry and exit.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_STOPGNT = 3'd1,
    ST_SLEEP   = 3'd2,
    ST_DEEP    = 3'd3,
    ST_DEEPER  = 3'd4,
    ST_PLLWAIT = 3'd5
  } pwrState_t;

  // control inputs, one bit each; polarity depends on use
  typedef struct packed {
    logic stp;
    logic slp;
    logic dpslp;
    logic dprstp;
  } ctlIn_t;

  localparam int NUM_CTL = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic runCnt;
    logic lowVid;
    logic quiet;
    logic guardDeep;
    logic guardDeeper;
    logic guardWait;
  } seqStrobe_t;

endpackage

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 750,
  parameter int VID_W = 7,
  parameter logic [VID_W-1:0] VID_NORM = 7'h2A,
  parameter logic [VID_W-1:0] VID_LOW = 7'h15,
  parameter int CST_W = 3,
  parameter int PST_W = 3,
  parameter int C4_CODE = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlIn_t           rawN,
  input  logic [CST_W-1:0] core0Idle,
  input  logic [CST_W-1:0] core1Idle,
  input  logic [PST_W-1:0] core0Perf,
  input  logic [PST_W-1:0] core1Perf,
  input  seqStrobe_t       strobe,
  output ctlIn_t           req,
  output logic             settleDone,
  output logic [VID_W-1:0] vidCode,
  output logic             snoopEn,
  output logic             intEn,
  output logic             pllWait,
  output logic             exitReq,
  output logic             violation
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [PST_W-1:0] PST_LOWEST = {PST_W{1'b1}};
  localparam logic [CST_W-1:0] IDLE_C4 = CST_W'(C4_CODE);

  logic [NUM_CTL-1:0] rawVec, metaQ, syncQ, prevQ, changed;
  logic [CNT_W-1:0]   cntQ;
  logic               badChange;

  assign rawVec = rawN;

  // two-flop synchronizer plus a history stage, per control bit
  for (genvar i = 0; i < NUM_CTL; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        metaQ[i] <= 1'b1;
        syncQ[i] <= 1'b1;
        prevQ[i] <= 1'b1;
      end else begin
        metaQ[i] <= rawVec[i];
        syncQ[i] <= metaQ[i];
        prevQ[i] <= syncQ[i];
      end
    end
  end

  assign req     = ctlIn_t'(~syncQ);
  assign changed = syncQ ^ prevQ;

  // bit order: stp(3) slp(2) dpslp(1) dprstp(0)
  always_comb begin
    badChange = 1'b0;
    if (strobe.guardDeep)   badChange = |(changed & 4'b1100);
    if (strobe.guardDeeper) badChange = |(changed & 4'b1110);
    if (strobe.guardWait)   badChange = |changed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          violation <= 1'b0;
    else if (badChange) violation <= 1'b1;
  end

  // PLL settle counter on the free-running clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntQ <= '0;
    else if (!strobe.runCnt) cntQ <= '0;
    else if (!settleDone)   cntQ <= cntQ + 1'b1;
  end

  assign settleDone = strobe.runCnt && (cntQ == CNT_LAST);
  assign pllWait    = strobe.runCnt;

  assign vidCode = strobe.lowVid ? VID_LOW : VID_NORM;
  assign snoopEn = !strobe.quiet;
  assign intEn   = !strobe.quiet;

  assign exitReq = strobe.lowVid &&
                   ((core0Idle != IDLE_C4) || (core1Idle != IDLE_C4) ||
                    (core0Perf != PST_LOWEST) || (core1Perf != PST_LOWEST));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlIn_t     req,
  input  logic       settleDone,
  output pwrState_t  state,
  output seqStrobe_t strobe
);

  pwrState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_NORMAL:  if (req.stp) stateD = ST_STOPGNT;
      ST_STOPGNT: if (!req.stp) stateD = ST_NORMAL;
                  else if (req.slp) stateD = ST_SLEEP;
      ST_SLEEP:   if (!req.slp) stateD = ST_STOPGNT;
                  else if (req.dpslp) stateD = ST_DEEP;
      ST_DEEP:    if (!req.dpslp) stateD = ST_PLLWAIT;
                  else if (req.dprstp) stateD = ST_DEEPER;
      ST_DEEPER:  if (!req.dprstp) stateD = ST_DEEP;
      ST_PLLWAIT: if (settleDone) stateD = ST_SLEEP;
      default:    stateD = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_NORMAL;
    else       stateQ <= stateD;
  end

  assign state              = stateQ;
  assign strobe.runCnt      = (stateQ == ST_PLLWAIT);
  assign strobe.lowVid      = (stateQ == ST_DEEPER);
  assign strobe.quiet       = (stateQ == ST_DEEP) || (stateQ == ST_DEEPER) ||
                              (stateQ == ST_PLLWAIT);
  assign strobe.guardDeep   = (stateQ == ST_DEEP);
  assign strobe.guardDeeper = (stateQ == ST_DEEPER);
  assign strobe.guardWait   = (stateQ == ST_PLLWAIT);

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pwr_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 750,
  parameter int VID_W = 7,
  parameter logic [VID_W-1:0] VID_NORM = 7'h2A,
  parameter logic [VID_W-1:0] VID_LOW = 7'h15,
  parameter int CST_W = 3,
  parameter int PST_W = 3,
  parameter int C4_CODE = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stpClkN,
  input  logic             slpN,
  input  logic             dpSlpN,
  input  logic             dprStpN,
  input  logic [CST_W-1:0] core0Idle,
  input  logic [CST_W-1:0] core1Idle,
  input  logic [PST_W-1:0] core0Perf,
  input  logic [PST_W-1:0] core1Perf,
  output logic [2:0]       pwrState,
  output logic [VID_W-1:0] vidCode,
  output logic             snoopEn,
  output logic             intEn,
  output logic             pllWait,
  output logic             exitReq,
  output logic             violation
);

  ctlIn_t     rawN, req;
  seqStrobe_t strobe;
  pwrState_t  state;
  logic       settleDone;

  assign rawN.stp    = stpClkN;
  assign rawN.slp    = slpN;
  assign rawN.dpslp  = dpSlpN;
  assign rawN.dprstp = dprStpN;

  pwr_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .settleDone(settleDone),
    .state(state), .strobe(strobe)
  );

  pwr_seq_dp #(
    .SETTLE_CYC(SETTLE_CYC), .VID_W(VID_W), .VID_NORM(VID_NORM),
    .VID_LOW(VID_LOW), .CST_W(CST_W), .PST_W(PST_W), .C4_CODE(C4_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rawN(rawN),
    .core0Idle(core0Idle), .core1Idle(core1Idle),
    .core0Perf(core0Perf), .core1Perf(core1Perf),
    .strobe(strobe), .req(req), .settleDone(settleDone),
    .vidCode(vidCode), .snoopEn(snoopEn), .intEn(intEn),
    .pllWait(pllWait), .exitReq(exitReq), .violation(violation)
  );

  assign pwrState = state;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int SETTLE_CYC = 750,
  parameter int VID_W = 7,
  parameter logic [VID_W-1:0] VID_NORM = 7'h2A,
  parameter logic [VID_W-1:0] VID_LOW = 7'h15
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       pwrState,
  input logic [VID_W-1:0] vidCode,
  input logic             snoopEn,
  input logic             intEn,
  input logic             pllWait,
  input logic             exitReq,
  input logic             violation
);

  localparam int LEN_W = $clog2(SETTLE_CYC + 2);
  logic [LEN_W-1:0] waitLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        waitLen <= '0;
    else if (pllWait) waitLen <= waitLen + 1'b1;
    else              waitLen <= '0;
  end

  assert_deep_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd3 && $past(pwrState) != 3'd3) |->
      ($past(pwrState) == 3'd2 || $past(pwrState) == 3'd4));

  assert_deeper_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd4 && $past(pwrState) != 3'd4) |-> $past(pwrState) == 3'd3);

  assert_vid_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd4) ? (vidCode == VID_LOW) : (vidCode == VID_NORM));

  assert_wait_exit_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwrState) == 3'd5 && pwrState != 3'd5) |-> pwrState == 3'd2);

  assert_wait_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    pllWait |-> waitLen < LEN_W'(SETTLE_CYC));

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd3 || pwrState == 3'd4 || pwrState == 3'd5) |-> (!snoopEn && !intEn));

  assert_exit_only_deeper_R9: assert property (@(posedge clk) disable iff (!rstN)
    exitReq |-> pwrState == 3'd4);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(violation) |-> violation);

endmodule

bind pwr_state_seq pwr_seq_chk #(
  .SETTLE_CYC(SETTLE_CYC), .VID_W(VID_W), .VID_NORM(VID_NORM), .VID_LOW(VID_LOW)
) u_chk (
  .clk(clk), .rstN(rstN), .pwrState(pwrState), .vidCode(vidCode),
  .snoopEn(snoopEn), .intEn(intEn), .pllWait(pllWait),
  .exitReq(exitReq), .violation(violation)
);

// File: tb/tb_pwr_state_seq.sv
module tb_pwr_state_seq;

  localparam int SETTLE = 5;
  localparam int CW = 3;
  localparam int PW = 2;
  localparam logic [6:0] VN = 7'h2A;
  localparam logic [6:0] VL = 7'h15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stpClkN = 1'b1, slpN = 1'b1, dpSlpN = 1'b1, dprStpN = 1'b1;
  logic [CW-1:0] core0Idle = '0, core1Idle = '0;
  logic [PW-1:0] core0Perf = '0, core1Perf = '0;
  logic [2:0] pwrState;
  logic [6:0] vidCode;
  logic snoopEn, intEn, pllWait, exitReq, violation;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pwr_state_seq #(
    .SETTLE_CYC(SETTLE), .VID_W(7), .VID_NORM(VN), .VID_LOW(VL),
    .CST_W(CW), .PST_W(PW), .C4_CODE(4)
  ) dut (
    .clk(clk), .rstN(rstN), .stpClkN(stpClkN), .slpN(slpN), .dpSlpN(dpSlpN),
    .dprStpN(dprStpN), .core0Idle(core0Idle), .core1Idle(core1Idle),
    .core0Perf(core0Perf), .core1Perf(core1Perf), .pwrState(pwrState),
    .vidCode(vidCode), .snoopEn(snoopEn), .intEn(intEn), .pllWait(pllWait),
    .exitReq(exitReq), .violation(violation)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkLevel(input string req, input int st);
    chk(req, pwrState, st);
    chk({req, " vid"}, vidCode, (st == 4) ? VL : VN);
    chk({req, " snoopEn"}, snoopEn, (st >= 3) ? 0 : 1);
    chk({req, " intEn"}, intEn, (st >= 3) ? 0 : 1);
    chk({req, " pllWait"}, pllWait, (st == 5) ? 1 : 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    stpClkN = 1'b1; slpN = 1'b1; dpSlpN = 1'b1; dprStpN = 1'b1;
    #1;
    chkLevel("R1 reset", 0);
    chk("R1 reset viol", violation, 0);
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic goDeep();
    stpClkN = 1'b0; step(3);
    slpN = 1'b0;    step(3);
    dpSlpN = 1'b0;  step(3);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    chkLevel("R1 during reset", 0);
    rstN = 1'b1;
    step(2);
    chkLevel("R1 after reset", 0);
    chk("R1 viol", violation, 0);

    // sleep ignored in Normal
    slpN = 1'b0; step(3);
    chkLevel("R3 sleep ignored in Normal", 0);
    slpN = 1'b1; step(3);

    // stop-clock latency: third edge
    stpClkN = 1'b0; step(2);
    chk("R11 not yet after two edges", pwrState, 0);
    step(1);
    chkLevel("R2 R11 enter Stop-Grant", 1);

    dpSlpN = 1'b0; step(3);
    chkLevel("R4 deep-sleep ignored in Stop-Grant", 1);
    dpSlpN = 1'b1; step(3);

    slpN = 1'b0; step(3);
    chkLevel("R3 enter Sleep", 2);
    dprStpN = 1'b0; step(3);
    chkLevel("R5 deeper-stop ignored in Sleep", 2);
    dprStpN = 1'b1; step(3);

    dpSlpN = 1'b0; step(3);
    chkLevel("R4 R8 enter Deep", 3);
    core0Idle = 3'd1;
    #1 chk("R9 no exitReq in Deep", exitReq, 0);
    core0Idle = '0;

    dprStpN = 1'b0; step(3);
    chkLevel("R5 R6 enter Deeper", 4);

    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int p = 0; p < 4; p++)
          for (int q = 0; q < 4; q++) begin
            core0Idle = CW'(a); core1Idle = CW'(b);
            core0Perf = PW'(p); core1Perf = PW'(q);
            #1 chk("R9 exitReq sweep", exitReq,
                   (a != 4 || b != 4 || p != 3 || q != 3) ? 1 : 0);
          end
    core0Idle = '0; core1Idle = '0; core0Perf = '0; core1Perf = '0;
    step(1);

    dprStpN = 1'b1; step(3);
    chkLevel("R6 back to Deep with normal vid", 3);
    chk("R10 allowed changes no viol", violation, 0);

    dpSlpN = 1'b1; step(3);
    chkLevel("R7 PLL wait entered", 5);
    step(SETTLE - 1);
    chkLevel("R7 PLL wait last cycle", 5);
    step(1);
    chkLevel("R7 R8 Sleep after settle", 2);
    chk("R10 no viol after clean exit", violation, 0);

    slpN = 1'b1; step(3);
    chkLevel("R3 back to Stop-Grant", 1);
    stpClkN = 1'b1; step(3);
    chkLevel("R2 back to Normal", 0);

    // violation in Deep
    goDeep();
    chk("R4 Deep again", pwrState, 3);
    stpClkN = 1'b1; step(3);
    chk("R10 viol set in Deep", violation, 1);
    chk("R10 level held", pwrState, 3);
    stpClkN = 1'b0; step(3);
    chk("R10 viol sticky", violation, 1);
    dpSlpN = 1'b1; step(3 + SETTLE);
    chk("R7 Sleep reached", pwrState, 2);
    chk("R10 viol still set", violation, 1);
    // reset from Sleep goes straight to Normal
    doReset();
    chkLevel("R1 Normal after reset from Sleep", 0);
    chk("R1 viol cleared", violation, 0);

    // violation in PLL wait
    goDeep();
    dpSlpN = 1'b1; step(3);
    chk("R7 wait again", pwrState, 5);
    slpN = 1'b1; step(3);
    chk("R10 viol in PLL wait", violation, 1);

    // violation in Deeper
    doReset();
    goDeep();
    dprStpN = 1'b0; step(3);
    chk("R5 Deeper again", pwrState, 4);
    chk("R10 clean so far", violation, 0);
    dpSlpN = 1'b1; step(3);
    chk("R10 viol in Deeper", violation, 1);
    chk("R10 stays Deeper", pwrState, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule